// File: doc/BRIEF.md
# Parameterised Adder-Subtractor with Status Flags

This block adds or subtracts two N-bit operands through one shared ripple-carry datapath. A single internal mode bit does two jobs at once. It inverts every bit of the second operand through a row of XOR gates, and it supplies the carry into the least significant position. The same adder therefore produces either A+B or A+~B+1, which is (A−B) mod 2^N. The datapath is built by chaining 4-bit ripple slices, with each slice's carry-out feeding the next slice's carry-in. N must be a multiple of 4.

The datapath has no signed or unsigned setting. One bit pattern serves both readings, and four flags describe it. The carry flag is the raw carry-out, so on a subtraction it reads as "no borrow". The overflow flag compares the carry into the top bit with the carry out of it. The zero flag and the negative flag are also provided.

A small operation decoder in front of the datapath steers the operands and the mode bit. This gives pass-through, increment, negate and compare without any extra arithmetic. The outputs are registered by default, giving one cycle of latency.

Top module: `addsub_unit`

## Requirements
- R1: With op = 0 (add), the result is (A+B) mod 2^N and carry is 1 exactly when A+B ≥ 2^N as unsigned values.
- R2: With op = 1 (subtract), the result is (A−B) mod 2^N and carry is 1 exactly when A ≥ B as unsigned values (0 signals a borrow).
- R3: Overflow is 1 exactly when the signed two's-complement value of the operation lies outside [−2^(N−1), 2^(N−1)−1].
- R4: Zero is 1 when every bit of the datapath sum is 0. Negative equals bit N−1 of the datapath sum.
- R5: Subtracting two equal operands, including both all ones, gives a zero result with carry 1 and overflow 0. This is the path where the carry ripples through every stage.
- R6: With op = 2 (pass), the result equals A, and carry and overflow are 0.
- R7: With op = 3 (increment), the unit subtracts all ones from A. The result is (A+1) mod 2^N, carry is 1 only for A all ones, and overflow is 1 only for A = 2^(N−1)−1.
- R8: With op = 4 (negate), the unit computes 0−A. The result is (−A) mod 2^N, carry is 1 only for A = 0, and overflow is 1 only for A = 2^(N−1).
- R9: With op = 5 (compare), the result output carries A unchanged. All four flags are those of A−B.
- R10: Op codes 6 and 7 behave as add.
- R11: While rst_n is low, every output is 0. After reset, the outputs reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_i | input | 3 | Operation code (see R1, R2, R6–R10) |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| result_o | output | N | Registered result |
| carry_o | output | 1 | Carry-out of the datapath; on subtraction, 1 means no borrow |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Datapath sum is zero |
| neg_o | output | 1 | Top bit of the datapath sum |

## Verification
The datapath holds no state, so any fault in an XOR gate, a carry link between slices or the mode-to-carry-in connection appears at the ports one cycle after the offending operands. It shows as a wrong result, a wrong carry or a wrong overflow. A break between slices only shows when a carry must cross a 4-bit boundary, and a lost carry-in only shows in subtract mode. For these reasons every 8-bit operand pair is driven in both modes. Dedicated vectors then cover the derived operations and their edge values: all ones, zero, and the most positive and most negative numbers.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_PASS = 3'd2,
        OP_INC  = 3'd3,
        OP_NEG  = 3'd4,
        OP_CMP  = 3'd5
    } op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } flags_t;

endpackage

// File: rtl/addsub_slice.sv
// 4-bit ripple-carry slice; also exposes the carry into its top bit.
module addsub_slice (
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    input  logic       c_i,
    output logic [3:0] s_o,
    output logic       c_o,
    output logic       c_top_o
);
    logic [4:0] c;

    always_comb begin
        c[0] = c_i;
        for (int k = 0; k < 4; k++) begin
            s_o[k]   = a_i[k] ^ b_i[k] ^ c[k];
            c[k+1]   = (a_i[k] & b_i[k]) | (c[k] & (a_i[k] ^ b_i[k]));
        end
    end

    assign c_o     = c[4];
    assign c_top_o = c[3];

endmodule

// File: rtl/addsub_core.sv
// N-bit adder-subtractor: one mode bit inverts B and feeds the first carry.
module addsub_core
    import addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         mode_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output flags_t       flags_o
);
    localparam int NS = N / SLICE_W;

    logic [N-1:0]  bx;
    logic [NS:0]   sc;
    logic [NS-1:0] ctop;

    assign bx    = b_i ^ {N{mode_i}};
    assign sc[0] = mode_i;

    for (genvar g = 0; g < NS; g++) begin : g_slice
        addsub_slice u_slice (
            .a_i     (a_i[g*SLICE_W +: SLICE_W]),
            .b_i     (bx[g*SLICE_W +: SLICE_W]),
            .c_i     (sc[g]),
            .s_o     (sum_o[g*SLICE_W +: SLICE_W]),
            .c_o     (sc[g+1]),
            .c_top_o (ctop[g])
        );

        // R1: carry into each slice's top bit matches the low three bits' sum
        always_comb begin
            if (!$isunknown({a_i, bx, sc[g]})) begin
                slice_top_carry_chk: assert (ctop[g] ==
                    (({1'b0, a_i[g*SLICE_W +: 3]} + {1'b0, bx[g*SLICE_W +: 3]}
                      + {3'b000, sc[g]}) >> 3 != 4'd0));
            end
        end
    end

    always_comb begin
        flags_o.carry = sc[NS];
        flags_o.ovf   = ctop[NS-1] ^ sc[NS];
        flags_o.zero  = (sum_o == '0);
        flags_o.neg   = sum_o[N-1];
    end

    always_comb begin
        if (!$isunknown({mode_i, a_i, b_i})) begin
            // R2
            sub_no_borrow_chk: assert (!mode_i || (flags_o.carry == (a_i >= b_i)));
            // R3
            ovf_sign_rule_chk: assert (flags_o.ovf ==
                ((a_i[N-1] == bx[N-1]) && (sum_o[N-1] != a_i[N-1])));
            // R5
            equal_sub_zero_chk: assert (!(mode_i && (a_i == b_i))
                || (sum_o == '0 && flags_o.carry && !flags_o.ovf));
        end
    end

endmodule

// File: rtl/addsub_unit.sv
// Operation decoder around the adder-subtractor, with an output register.
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] result_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         zero_o,
    output logic         neg_o
);
    typedef struct packed {
        logic [N-1:0] res;
        flags_t       fl;
    } out_t;

    op_e          op;
    logic         mode;
    logic [N-1:0] opa;
    logic [N-1:0] opb;
    logic [N-1:0] sum;
    flags_t       fl;
    out_t         out_d;
    out_t         out_q;

    assign op = op_e'(op_i);

    always_comb begin
        mode = 1'b0;
        opa  = a_i;
        opb  = b_i;
        unique case (op)
            OP_SUB:  mode = 1'b1;
            OP_PASS: opb  = '0;
            OP_INC: begin
                mode = 1'b1;
                opb  = '1;
            end
            OP_NEG: begin
                mode = 1'b1;
                opa  = '0;
                opb  = a_i;
            end
            OP_CMP:  mode = 1'b1;
            default: mode = 1'b0;
        endcase
    end

    addsub_core #(.N(N)) u_core (
        .mode_i  (mode),
        .a_i     (opa),
        .b_i     (opb),
        .sum_o   (sum),
        .flags_o (fl)
    );

    always_comb begin
        out_d.res = (op == OP_CMP) ? a_i : sum;
        out_d.fl  = fl;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        // R6
        pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd2) |=> (result_o == $past(a_i) && !carry_o && !ovf_o));
        // R9
        compare_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd5) |=> (result_o == $past(a_i)));
        // R4
        neg_follows_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i != 3'd5) |=> (neg_o == result_o[N-1] && zero_o == (result_o == '0)));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign result_o = out_q.res;
    assign carry_o  = out_q.fl.carry;
    assign ovf_o    = out_q.fl.ovf;
    assign zero_o   = out_q.fl.zero;
    assign neg_o    = out_q.fl.neg;

endmodule

// File: tb/addsub_unit_bench.sv
module addsub_unit_bench;
    localparam int  N      = 8;
    localparam time PERIOD = 10;
    localparam int  MAXV   = (1 << N);

    typedef struct {
        logic [N-1:0] res;
        logic         c;
        logic         v;
        logic         z;
        logic         n;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] b_i = '0;
    logic [N-1:0] result_o;
    logic         carry_o, ovf_o, zero_o, neg_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    addsub_unit #(.N(N)) u_addsub_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o),
        .zero_o(zero_o), .neg_o(neg_o)
    );

    // Reference from integer arithmetic, not from gates.
    function automatic exp_t model(int a, int b, bit sub, string tag);
        exp_t e;
        int full, sa, sb, sv;
        full  = sub ? (a - b) : (a + b);
        e.res = N'((full + 2*MAXV) % MAXV);
        e.c   = sub ? (a >= b) : (a + b >= MAXV);
        sa    = (a >= MAXV/2) ? a - MAXV : a;
        sb    = (b >= MAXV/2) ? b - MAXV : b;
        sv    = sub ? (sa - sb) : (sa + sb);
        e.v   = (sv > MAXV/2 - 1) || (sv < -(MAXV/2));
        e.z   = (e.res == '0);
        e.n   = e.res[N-1];
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(int op, int a, int b, string tag);
        exp_t e;
        case (op)
            1, 5:    e = model(a, b, 1'b1, tag);
            2:       e = model(a, 0, 1'b0, tag);
            3:       e = model(a, MAXV-1, 1'b1, tag);
            4:       e = model(0, a, 1'b1, tag);
            default: e = model(a, b, 1'b0, tag);
        endcase
        if (op == 5) e.res = N'(a);
        @(negedge clk);
        op_i = 3'(op);
        a_i  = N'(a);
        b_i  = N'(b);
        q.push_back(e);
    endtask

    // Monitor: the registered output appears at the edge after the drive.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (result_o !== e.res || carry_o !== e.c || ovf_o !== e.v
                    || zero_o !== e.z || neg_o !== e.n) begin
                    fails++;
                    $display("FAIL %s res/c/v/z/n = %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                             e.tag, result_o, carry_o, ovf_o, zero_o, neg_o,
                             e.res, e.c, e.v, e.z, e.n);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        #(PERIOD + 2);
        checks++;
        if ({result_o, carry_o, ovf_o, zero_o, neg_o} !== '0) begin
            fails++;
            $display("FAIL R11 outputs %h expected 0",
                     {result_o, carry_o, ovf_o, zero_o, neg_o});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1, R2 exhaustive; also covers R3, R4 bit patterns
        for (int a = 0; a < MAXV; a++)
            for (int b = 0; b < MAXV; b++) begin
                drive(0, a, b, "R1");
                drive(1, a, b, "R2");
            end

        // R3: overflow corners
        drive(0, 8'h7F, 8'h01, "R3");
        drive(0, 8'h80, 8'hFF, "R3");
        drive(1, 8'h80, 8'h01, "R3");
        drive(1, 8'h7F, 8'hFF, "R3");
        drive(1, 8'h00, 8'h80, "R3");
        // R4: zero and negative
        drive(0, 8'hFF, 8'h01, "R4");
        drive(1, 8'h00, 8'h01, "R4");
        // R5: full ripple on equal operands
        drive(1, 8'hFF, 8'hFF, "R5");
        drive(1, 8'h00, 8'h00, "R5");
        drive(1, 8'h5A, 8'h5A, "R5");
        // R6: pass
        for (int a = 0; a < MAXV; a += 37) drive(2, a, 8'hC3, "R6");
        drive(2, 8'hFF, 8'hFF, "R6");
        // R7: increment
        drive(3, 8'h00, 8'h55, "R7");
        drive(3, 8'h7F, 8'h00, "R7");
        drive(3, 8'hFF, 8'h00, "R7");
        drive(3, 8'h0F, 8'hAA, "R7");
        // R8: negate
        drive(4, 8'h00, 8'h11, "R8");
        drive(4, 8'h80, 8'h00, "R8");
        drive(4, 8'h01, 8'h00, "R8");
        drive(4, 8'h7F, 8'hFF, "R8");
        // R9: compare
        drive(5, 8'h10, 8'h20, "R9");
        drive(5, 8'h20, 8'h10, "R9");
        drive(5, 8'h44, 8'h44, "R9");
        drive(5, 8'h80, 8'h7F, "R9");
        // R10: spare codes act as add
        drive(6, 8'h90, 8'h90, "R10");
        drive(7, 8'h12, 8'h34, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule